// File: doc/BRIEF.md
# Power Sequence Command Engine

This block is a hardware sequencer that runs one power-up or power-down recipe on request. A single-cycle `start` pulse makes it walk a command table held in a ROM-style read port, from index zero upward. Before it acts on an entry, it checks the entry's three version masks against the fab, cut and interface inputs. An entry that fails this filter is skipped.

Each entry that passes the filter is carried out over a byte-wide register bus. This bus reaches either the system register space or a local bus-interface space. The engine supports the following commands:

- masked read-modify-write;
- masked polling, with an attempt budget shared by the whole recipe;
- waits counted in microseconds or milliseconds;
- a no-op read;
- end.

When the recipe finishes, the engine raises `done` together with a `pass` flag. Both stay set until the next start pulse.

The parameter `CYC_PER_US` gives the number of clock cycles in one microsecond. `GAP_US` sets the pause between failed poll attempts. `POLL_LIMIT` sets the shared attempt budget.

Top module: `pwr_seq_engine`

## Requirements
- R1: A table entry is 45 bits wide. From MSB to LSB it holds: command[3:0], fab mask[3:0], cut mask[3:0], interface mask[3:0], a local-space flag[0], offset[11:0], mask[7:0], value[7:0]. The command codes are 0 read, 1 write, 2 poll, 3 delay and 4 end. Every other code is a no-op.
- R2: An entry runs only when all three of these are nonzero: its fab mask AND `fabVer`, its cut mask AND `cutVer`, and its interface mask AND `intfVer`. Any other entry is skipped with no bus access.
- R3: A write first reads the byte at the offset. It then writes back (read AND NOT mask) OR (value AND mask) to the same offset. The local-space flag chooses the space: 1 means local (`busLocal`=1), 0 means system.
- R4: A poll reads the byte at the offset, in the space the flag selects. It completes when (read AND mask) equals (value AND mask). Successive attempts are spaced by at least GAP_US*CYC_PER_US cycles.
- R5: The poll attempt counter is cleared once per start and is shared by every poll in the recipe. An attempt made while more than POLL_LIMIT attempts have already been counted ends the recipe as failed, whatever the data. So attempt number POLL_LIMIT+1 may still succeed, and attempt POLL_LIMIT+2 fails.
- R6: A delay waits offset*CYC_PER_US cycles when its value is 0. For any other value it waits offset*1000*CYC_PER_US cycles. A zero offset does not wait at all.
- R7: An end entry sets `done`=1 and `pass`=1. Read and unrecognised commands make no bus access and move on to the next index.
- R8: A poll timeout sets `done`=1 and `pass`=0. It ends all bus activity, and no later entry runs.
- R9: `busReq`, `busAddr`, `busWe`, `busLocal`, `busWdata` and `tblAddr` hold steady until `busAck`. Read data is taken in the acknowledge cycle.
- R10: `done` and `pass` hold until the next start, which clears them. A start that arrives while a recipe is running is ignored.
- R11: After reset, `done`, `pass` and `busReq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that starts a recipe |
| fabVer | input | 4 | Fab version bits |
| cutVer | input | 4 | Cut version bits |
| intfVer | input | 4 | Interface type bits |
| tblAddr | output | 6 | Command table index |
| tblData | input | 45 | Table entry at `tblAddr` (combinational read) |
| busReq | output | 1 | Register access request |
| busWe | output | 1 | 1 = write, 0 = read |
| busLocal | output | 1 | 1 = local bus-interface space, 0 = system space |
| busAddr | output | 12 | Register byte offset |
| busWdata | output | 8 | Write data |
| busRdata | input | 8 | Read data, valid with `busAck` |
| busAck | input | 1 | Access acknowledge |
| done | output | 1 | Recipe finished |
| pass | output | 1 | Recipe ended by an end entry |

## Verification
The engine accepts a start pulse at the first rising edge. Its first table fetch happens one edge later. From then on, each bus access ends on the edge that samples `busAck`, and the results of a recipe become visible only once `done` rises. For this reason the bench waits for `done` at falling edges before it compares the memory images of both spaces, the number of transactions and the number of poll reads. The timing checks (delay length and poll spacing) are made against windows, not exact cycles. A delay must fall within a dozen cycles of its nominal count, and each poll gap must reach its minimum. This leaves room for the one or two cycles of fetch and check that surround every wait, and for the random acknowledge latency of the bus model.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  parameter int CMD_W = 4;
  parameter int VER_W = 4;
  parameter int OFF_W = 12;
  parameter int DAT_W = 8;
  parameter int IDX_W = 6;

  localparam logic [CMD_W-1:0] OP_READ  = 4'd0;
  localparam logic [CMD_W-1:0] OP_WRITE = 4'd1;
  localparam logic [CMD_W-1:0] OP_POLL  = 4'd2;
  localparam logic [CMD_W-1:0] OP_DELAY = 4'd3;
  localparam logic [CMD_W-1:0] OP_END   = 4'd4;

  typedef struct packed {
    logic [CMD_W-1:0] cmd;
    logic [VER_W-1:0] fabMask;
    logic [VER_W-1:0] cutMask;
    logic [VER_W-1:0] intfMask;
    logic             localSpace;
    logic [OFF_W-1:0] offset;
    logic [DAT_W-1:0] mask;
    logic [DAT_W-1:0] value;
  } seq_entry_t;

  localparam int ENTRY_W = $bits(seq_entry_t);

  // strobes from control to datapath
  typedef struct packed {
    logic clrSeq;
    logic latchEntry;
    logic capRead;
    logic incIdx;
    logic incPoll;
    logic loadDelay;
    logic loadGap;
    logic cntDec;
  } seq_strobe_t;
endpackage

// File: rtl/pwr_seq_datapath.sv
module pwr_seq_datapath
  import pwr_seq_pkg::*;
#(
  parameter int CYC_PER_US = 50,
  parameter int GAP_US     = 10,
  parameter int POLL_LIMIT = 5000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  seq_strobe_t        stb,
  input  logic [ENTRY_W-1:0] tblData,
  input  logic [VER_W-1:0]   fabVer,
  input  logic [VER_W-1:0]   cutVer,
  input  logic [VER_W-1:0]   intfVer,
  input  logic [DAT_W-1:0]   busRdata,
  output logic [IDX_W-1:0]   tblAddr,
  output seq_entry_t         cur,
  output logic               fMatch,
  output logic [CMD_W-1:0]   fCmd,
  output logic               fDelayZero,
  output logic               pollOver,
  output logic               pollHit,
  output logic               cntLast,
  output logic [DAT_W-1:0]   busWdata
);
  localparam int MS_MULT = 1000;
  localparam int MAX_DLY = ((2 ** OFF_W) - 1) * MS_MULT * CYC_PER_US;
  localparam int DLY_W   = $clog2(MAX_DLY + 1);
  localparam int GAP_CYC = GAP_US * CYC_PER_US;
  localparam int PCNT_W  = $clog2(POLL_LIMIT + 2) + 1;
  localparam int NFIELD  = 3;

  seq_entry_t         fetched;
  seq_entry_t         curR;
  logic [IDX_W-1:0]   idx;
  logic [DAT_W-1:0]   rdReg;
  logic [PCNT_W-1:0]  pollCnt;
  logic [DLY_W-1:0]   dlyCnt;
  logic [DLY_W-1:0]   unitCyc;
  logic [DLY_W-1:0]   fDelayCyc;
  logic [VER_W-1:0]   selMask [NFIELD];
  logic [VER_W-1:0]   selVer  [NFIELD];
  logic [NFIELD-1:0]  fieldHit;

  assign fetched = seq_entry_t'(tblData);

  assign selMask[0] = fetched.fabMask;
  assign selMask[1] = fetched.cutMask;
  assign selMask[2] = fetched.intfMask;
  assign selVer[0]  = fabVer;
  assign selVer[1]  = cutVer;
  assign selVer[2]  = intfVer;

  for (genvar g = 0; g < NFIELD; g++) begin : gFilter
    assign fieldHit[g] = |(selMask[g] & selVer[g]);
  end

  assign fMatch     = &fieldHit;
  assign fCmd       = fetched.cmd;
  assign fDelayZero = (fetched.offset == '0);

  always_comb begin
    unitCyc   = (fetched.value == '0) ? DLY_W'(CYC_PER_US) : DLY_W'(MS_MULT * CYC_PER_US);
    fDelayCyc = DLY_W'(fetched.offset) * unitCyc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx     <= '0;
      pollCnt <= '0;
      curR    <= '0;
      rdReg   <= '0;
      dlyCnt  <= '0;
    end else begin
      if (stb.clrSeq) begin
        idx     <= '0;
        pollCnt <= '0;
      end else begin
        if (stb.incIdx)  idx     <= idx + 1'b1;
        if (stb.incPoll) pollCnt <= pollCnt + 1'b1;
      end
      if (stb.latchEntry) curR  <= fetched;
      if (stb.capRead)    rdReg <= busRdata;
      if (stb.loadDelay)      dlyCnt <= fDelayCyc;
      else if (stb.loadGap)   dlyCnt <= DLY_W'(GAP_CYC);
      else if (stb.cntDec)    dlyCnt <= dlyCnt - 1'b1;
    end
  end

  assign tblAddr  = idx;
  assign cur      = curR;
  assign pollOver = pollCnt > PCNT_W'(POLL_LIMIT);
  assign pollHit  = (rdReg & curR.mask) == (curR.value & curR.mask);
  assign cntLast  = (dlyCnt <= DLY_W'(1));
  assign busWdata = (rdReg & ~curR.mask) | (curR.value & curR.mask);
endmodule

// File: rtl/pwr_seq_control.sv
module pwr_seq_control
  import pwr_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             fMatch,
  input  logic [CMD_W-1:0] fCmd,
  input  logic             fDelayZero,
  input  logic [CMD_W-1:0] curCmd,
  input  logic             pollOver,
  input  logic             pollHit,
  input  logic             cntLast,
  input  logic             busAck,
  output seq_strobe_t      stb,
  output logic             busReq,
  output logic             busWe,
  output logic             done,
  output logic             pass
);
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_READ, S_WRITE, S_CHECK, S_WAIT
  } state_e;

  state_e state, nxt;
  logic   finOk, finFail;

  always_comb begin
    stb     = '0;
    nxt     = state;
    finOk   = 1'b0;
    finFail = 1'b0;
    case (state)
      S_IDLE: begin
        if (start) begin
          stb.clrSeq = 1'b1;
          nxt        = S_FETCH;
        end
      end
      S_FETCH: begin
        if (!fMatch) begin
          stb.incIdx = 1'b1;
        end else begin
          case (fCmd)
            OP_WRITE, OP_POLL: begin
              stb.latchEntry = 1'b1;
              nxt            = S_READ;
            end
            OP_DELAY: begin
              if (fDelayZero) begin
                stb.incIdx = 1'b1;
              end else begin
                stb.latchEntry = 1'b1;
                stb.loadDelay  = 1'b1;
                nxt            = S_WAIT;
              end
            end
            OP_END: begin
              finOk = 1'b1;
              nxt   = S_IDLE;
            end
            default: stb.incIdx = 1'b1;
          endcase
        end
      end
      S_READ: begin
        if (busAck) begin
          stb.capRead = 1'b1;
          nxt         = (curCmd == OP_POLL) ? S_CHECK : S_WRITE;
        end
      end
      S_WRITE: begin
        if (busAck) begin
          stb.incIdx = 1'b1;
          nxt        = S_FETCH;
        end
      end
      S_CHECK: begin
        if (pollOver) begin
          finFail = 1'b1;
          nxt     = S_IDLE;
        end else begin
          stb.incPoll = 1'b1;
          if (pollHit) begin
            stb.incIdx = 1'b1;
            nxt        = S_FETCH;
          end else begin
            stb.loadGap = 1'b1;
            nxt         = S_WAIT;
          end
        end
      end
      S_WAIT: begin
        if (cntLast) begin
          if (curCmd == OP_POLL) begin
            nxt = S_READ;
          end else begin
            stb.incIdx = 1'b1;
            nxt        = S_FETCH;
          end
        end else begin
          stb.cntDec = 1'b1;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      done  <= 1'b0;
      pass  <= 1'b0;
    end else begin
      state <= nxt;
      if (stb.clrSeq) begin
        done <= 1'b0;
        pass <= 1'b0;
      end else if (finOk) begin
        done <= 1'b1;
        pass <= 1'b1;
      end else if (finFail) begin
        done <= 1'b1;
        pass <= 1'b0;
      end
    end
  end

  assign busReq = (state == S_READ) || (state == S_WRITE);
  assign busWe  = (state == S_WRITE);
endmodule

// File: rtl/pwr_seq_engine.sv
module pwr_seq_engine
  import pwr_seq_pkg::*;
#(
  parameter int CYC_PER_US = 50,
  parameter int GAP_US     = 10,
  parameter int POLL_LIMIT = 5000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [VER_W-1:0]   fabVer,
  input  logic [VER_W-1:0]   cutVer,
  input  logic [VER_W-1:0]   intfVer,
  output logic [IDX_W-1:0]   tblAddr,
  input  logic [ENTRY_W-1:0] tblData,
  output logic               busReq,
  output logic               busWe,
  output logic               busLocal,
  output logic [OFF_W-1:0]   busAddr,
  output logic [DAT_W-1:0]   busWdata,
  input  logic [DAT_W-1:0]   busRdata,
  input  logic               busAck,
  output logic               done,
  output logic               pass
);
  seq_strobe_t      stb;
  seq_entry_t       cur;
  logic             fMatch, fDelayZero, pollOver, pollHit, cntLast;
  logic [CMD_W-1:0] fCmd;

  pwr_seq_control uCtrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .fMatch(fMatch), .fCmd(fCmd), .fDelayZero(fDelayZero),
    .curCmd(cur.cmd), .pollOver(pollOver), .pollHit(pollHit),
    .cntLast(cntLast), .busAck(busAck), .stb(stb),
    .busReq(busReq), .busWe(busWe), .done(done), .pass(pass)
  );

  pwr_seq_datapath #(
    .CYC_PER_US(CYC_PER_US), .GAP_US(GAP_US), .POLL_LIMIT(POLL_LIMIT)
  ) uData (
    .clk(clk), .rst_n(rst_n), .stb(stb), .tblData(tblData),
    .fabVer(fabVer), .cutVer(cutVer), .intfVer(intfVer),
    .busRdata(busRdata), .tblAddr(tblAddr), .cur(cur),
    .fMatch(fMatch), .fCmd(fCmd), .fDelayZero(fDelayZero),
    .pollOver(pollOver), .pollHit(pollHit), .cntLast(cntLast),
    .busWdata(busWdata)
  );

  assign busAddr  = cur.offset;
  assign busLocal = cur.localSpace;
endmodule

// File: rtl/pwr_seq_checker.sv
module pwr_seq_checker
  import pwr_seq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [IDX_W-1:0] tblAddr,
  input logic             busReq,
  input logic             busWe,
  input logic             busLocal,
  input logic [OFF_W-1:0] busAddr,
  input logic [DAT_W-1:0] busWdata,
  input logic             busAck,
  input logic             done,
  input logic             pass
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busReq && !busAck |=> busReq && $stable(busAddr) && $stable(busWe)
                          && $stable(busLocal) && $stable(busWdata));

  // R9
  index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busReq && !busAck |=> $stable(tblAddr));

  // R8
  quiet_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busReq);

  // R10
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(pass));

  // R7
  pass_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done);
endmodule

bind pwr_seq_engine pwr_seq_checker uChk (
  .clk(clk), .rst_n(rst_n), .start(start), .tblAddr(tblAddr),
  .busReq(busReq), .busWe(busWe), .busLocal(busLocal), .busAddr(busAddr),
  .busWdata(busWdata), .busAck(busAck), .done(done), .pass(pass)
);

// File: tb/pwr_seq_engine_test.sv
`timescale 1ns/1ps
module pwr_seq_engine_test;
  import pwr_seq_pkg::*;

  localparam int CYC   = 2;
  localparam int GAPUS = 10;
  localparam int LIM   = 6;
  localparam int GAPC  = CYC * GAPUS;
  localparam logic [7:0] PA = 8'hF0;
  localparam logic [7:0] PB = 8'hF1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [VER_W-1:0] fabVer = 4'hF, cutVer = 4'hF, intfVer = 4'hF;
  logic [IDX_W-1:0] tblAddr;
  logic [ENTRY_W-1:0] tblData;
  logic busReq, busWe, busLocal, done, pass;
  logic [OFF_W-1:0] busAddr;
  logic [DAT_W-1:0] busWdata;
  logic [DAT_W-1:0] busRdata = '0;
  logic busAck = 1'b0;

  logic [ENTRY_W-1:0] rom [64];
  logic [7:0] memSys [256];
  logic [7:0] memLoc [256];
  logic [7:0] expSys [256];
  logic [7:0] expLoc [256];

  int nChk = 0, nFail = 0, cyc = 0;
  int txCount = 0, wrCount = 0, pollReads = 0, flipAfter = 0;
  int lastPollCyc = 0, gapViol = 0, lat = 0;
  logic [7:0] pollTarget = 8'h00;

  assign tblData = rom[tblAddr];

  always #10 clk = ~clk;  // 50 MHz

  pwr_seq_engine #(.CYC_PER_US(CYC), .GAP_US(GAPUS), .POLL_LIMIT(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .fabVer(fabVer), .cutVer(cutVer),
    .intfVer(intfVer), .tblAddr(tblAddr), .tblData(tblData), .busReq(busReq),
    .busWe(busWe), .busLocal(busLocal), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busAck(busAck), .done(done), .pass(pass)
  );

  function automatic logic [ENTRY_W-1:0] mkE(logic [3:0] c, logic [3:0] f, logic [3:0] k,
      logic [3:0] n, logic l, logic [11:0] o, logic [7:0] m, logic [7:0] v);
    seq_entry_t e;
    e.cmd = c; e.fabMask = f; e.cutMask = k; e.intfMask = n;
    e.localSpace = l; e.offset = o; e.mask = m; e.value = v;
    return e;
  endfunction

  function automatic logic [7:0] rmw(logic [7:0] old, logic [7:0] m, logic [7:0] v);
    return (old & ~m) | (v & m);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  // bus slave model
  initial begin
    forever begin
      @(negedge clk);
      if (busAck) begin
        busAck = 1'b0;
      end else if (busReq) begin
        if (lat > 0) lat--;
        else begin
          busAck = 1'b1;
          txCount++;
          if (busWe) begin
            wrCount++;
            if (busLocal) memLoc[busAddr[7:0]] = busWdata;
            else          memSys[busAddr[7:0]] = busWdata;
          end else begin
            busRdata = busLocal ? memLoc[busAddr[7:0]] : memSys[busAddr[7:0]];
            if (!busLocal && (busAddr[7:0] == PA || busAddr[7:0] == PB)) begin
              pollReads++;
              if (busAddr[7:0] == PA && flipAfter != 0 && pollReads >= flipAfter)
                busRdata = pollTarget;
              if (pollReads > 1 && (cyc - lastPollCyc) < GAPC) gapViol++;
              lastPollCyc = cyc;
            end
          end
          lat = $urandom % 3;
        end
      end
    end
  end

  // cycle counter and watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        check(0, "watchdog", cyc, 150000);
        finishRun();
      end
    end
  end

  task automatic clearAll();
    for (int i = 0; i < 64; i++) rom[i] = mkE(OP_END, 4'hF, 4'hF, 4'hF, 0, 0, 0, 0);
    for (int i = 0; i < 256; i++) begin memSys[i] = '0; memLoc[i] = '0; end
    txCount = 0; wrCount = 0; pollReads = 0; flipAfter = 0; gapViol = 0;
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic runSeq(output int n);
    pulseStart();
    n = 1;
    while (!done) begin @(negedge clk); n++; end
  endtask

  task automatic modelRun();
    seq_entry_t e;
    for (int i = 0; i < 256; i++) begin expSys[i] = memSys[i]; expLoc[i] = memLoc[i]; end
    for (int i = 0; i < 64; i++) begin
      e = seq_entry_t'(rom[i]);
      if (|(e.fabMask & fabVer) && |(e.cutMask & cutVer) && |(e.intfMask & intfVer)) begin
        if (e.cmd == OP_END) break;
        if (e.cmd == OP_WRITE) begin
          if (e.localSpace) expLoc[e.offset[7:0]] = rmw(expLoc[e.offset[7:0]], e.mask, e.value);
          else              expSys[e.offset[7:0]] = rmw(expSys[e.offset[7:0]], e.mask, e.value);
        end
      end
    end
  endtask

  task automatic cmpMem(input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < 256; i++)
      if (memSys[i] !== expSys[i] || memLoc[i] !== expLoc[i]) bad++;
    check(bad == 0, req, bad, 0);
  endtask

  initial begin
    int n;
    void'($urandom(32'd20240611));
    clearAll();
    repeat (3) @(negedge clk);
    // R11 reset state
    check(done == 0 && pass == 0 && busReq == 0, "R11", {done, pass, busReq}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 write in both spaces, R1 encoding
    clearAll();
    memSys[8'h30] = 8'hA5; memLoc[8'h30] = 8'h3C;
    rom[0] = mkE(OP_WRITE, 4'hF, 4'hF, 4'hF, 0, 12'h030, 8'h0F, 8'h96);
    rom[1] = mkE(OP_WRITE, 4'hF, 4'hF, 4'hF, 1, 12'h030, 8'hF0, 8'h81);
    runSeq(n);
    check(memSys[8'h30] == 8'hA6, "R3 system rmw", memSys[8'h30], 8'hA6);
    check(memLoc[8'h30] == 8'h8C, "R3 local rmw", memLoc[8'h30], 8'h8C);
    check(pass == 1 && txCount == 4, "R7 end pass", {pass, 8'(txCount)}, 9'h104);

    // R2 filtering
    clearAll();
    fabVer = 4'b0010; cutVer = 4'b0001; intfVer = 4'b0100;
    rom[0] = mkE(OP_WRITE, 4'b0001, 4'hF, 4'hF, 0, 12'h020, 8'hFF, 8'h11);
    rom[1] = mkE(OP_WRITE, 4'hF, 4'b1110, 4'hF, 0, 12'h021, 8'hFF, 8'h22);
    rom[2] = mkE(OP_WRITE, 4'hF, 4'hF, 4'b1011, 0, 12'h022, 8'hFF, 8'h33);
    rom[3] = mkE(OP_WRITE, 4'b0110, 4'b0011, 4'b0100, 0, 12'h023, 8'hFF, 8'h44);
    runSeq(n);
    check(memSys[8'h20] == 0 && memSys[8'h21] == 0 && memSys[8'h22] == 0,
          "R2 skipped entries", {memSys[8'h20], memSys[8'h21], memSys[8'h22]}, 0);
    check(memSys[8'h23] == 8'h44 && txCount == 2, "R2 matched entry", memSys[8'h23], 8'h44);
    fabVer = 4'hF; cutVer = 4'hF; intfVer = 4'hF;

    // R7 read and unknown codes are no-ops
    clearAll();
    rom[0] = mkE(OP_READ, 4'hF, 4'hF, 4'hF, 0, 12'h010, 8'hFF, 8'hFF);
    rom[1] = mkE(4'd9, 4'hF, 4'hF, 4'hF, 0, 12'h010, 8'hFF, 8'hFF);
    runSeq(n);
    check(txCount == 0 && pass == 1, "R7 no-op commands", txCount, 0);

    // R6 delays
    clearAll();
    rom[0] = mkE(OP_DELAY, 4'hF, 4'hF, 4'hF, 0, 12'd5, 8'h00, 8'h00);
    runSeq(n);
    check(n >= 5 * CYC && n <= 5 * CYC + 12, "R6 us delay", n, 5 * CYC);
    clearAll();
    rom[0] = mkE(OP_DELAY, 4'hF, 4'hF, 4'hF, 0, 12'd2, 8'h00, 8'h01);
    runSeq(n);
    check(n >= 2000 * CYC && n <= 2000 * CYC + 12, "R6 ms delay", n, 2000 * CYC);
    clearAll();
    rom[0] = mkE(OP_DELAY, 4'hF, 4'hF, 4'hF, 0, 12'd0, 8'h00, 8'h01);
    runSeq(n);
    check(n <= 8, "R6 zero delay", n, 8);

    // R4 poll succeeds on third read, spacing respected
    clearAll();
    flipAfter = 3; pollTarget = 8'h81;
    rom[0] = mkE(OP_POLL, 4'hF, 4'hF, 4'hF, 0, {4'h0, PA}, 8'h01, 8'h01);
    runSeq(n);
    check(pass == 1 && pollReads == 3, "R4 poll reads", pollReads, 3);
    check(gapViol == 0, "R4 poll spacing", gapViol, 0);

    // R5 R8 shared budget across two polls
    clearAll();
    flipAfter = 4; pollTarget = 8'h01;
    rom[0] = mkE(OP_POLL, 4'hF, 4'hF, 4'hF, 0, {4'h0, PA}, 8'h01, 8'h01);
    rom[1] = mkE(OP_POLL, 4'hF, 4'hF, 4'hF, 0, {4'h0, PB}, 8'h01, 8'h01);
    rom[2] = mkE(OP_WRITE, 4'hF, 4'hF, 4'hF, 0, 12'h040, 8'hFF, 8'h77);
    runSeq(n);
    check(done == 1 && pass == 0, "R8 timeout fails", pass, 0);
    check(pollReads == LIM + 2, "R5 shared budget", pollReads, LIM + 2);
    n = txCount;
    repeat (30) @(negedge clk);
    check(txCount == n && wrCount == 0 && memSys[8'h40] == 0, "R8 stops", wrCount, 0);

    // R5 boundary: attempt LIM+1 still passes, budget cleared per start
    clearAll();
    flipAfter = LIM + 1; pollTarget = 8'h01;
    rom[0] = mkE(OP_POLL, 4'hF, 4'hF, 4'hF, 0, {4'h0, PA}, 8'h01, 8'h01);
    runSeq(n);
    check(pass == 1 && pollReads == LIM + 1, "R5 last allowed attempt", pollReads, LIM + 1);

    // R10 start ignored while busy, status holds, start clears
    clearAll();
    rom[0] = mkE(OP_WRITE, 4'hF, 4'hF, 4'hF, 0, 12'h050, 8'hFF, 8'h5A);
    rom[1] = mkE(OP_DELAY, 4'hF, 4'hF, 4'hF, 0, 12'd20, 8'h00, 8'h00);
    pulseStart();
    repeat (15) @(negedge clk);
    pulseStart();
    while (!done) @(negedge clk);
    check(txCount == 2, "R10 busy start ignored", txCount, 2);
    repeat (10) @(negedge clk);
    check(done == 1 && pass == 1, "R10 status holds", {done, pass}, 3);
    pulseStart();
    check(done == 0 && pass == 0, "R10 start clears", {done, pass}, 0);
    while (!done) @(negedge clk);

    // random tables against the bench model (R2 R3)
    for (int t = 0; t < 8; t++) begin
      clearAll();
      for (int i = 0; i < 256; i++) begin memSys[i] = 8'($urandom); memLoc[i] = 8'($urandom); end
      fabVer = 4'($urandom % 15 + 1); cutVer = 4'($urandom % 15 + 1); intfVer = 4'($urandom % 15 + 1);
      for (int i = 0; i < 10; i++) begin
        logic [3:0] c;
        case ($urandom % 4)
          0: c = OP_READ;
          3: c = 4'd7;
          default: c = OP_WRITE;
        endcase
        rom[i] = mkE(c, 4'($urandom), 4'($urandom), 4'($urandom), 1'($urandom),
                     12'($urandom % 128), 8'($urandom), 8'($urandom));
      end
      modelRun();
      runSeq(n);
      cmpMem("R3 random table");
    end

    finishRun();
  end
endmodule